// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Sequencer

This block is an SPI master for a 4- or 8-channel successive-approximation converter. One pulse on the trigger input starts a scan over the channels set in the enable mask. The mask and the converter settings (power mode, range, coding) are captured when the trigger is taken. For each enabled channel, lowest index first, the block sends a command frame, keeps chip select high for a guard gap, and then runs a second frame that reads the conversion back.

The read frame carries a 4-bit channel tag above a left-justified sample. When the tag equals the channel that was commanded, the block presents the sample at the configured resolution (8, 10 or 12 bits) together with its channel number and a one-cycle valid strobe. When the tag differs, the block drops the sample and pulses an error flag instead. In both cases the scan continues with the next enabled channel. A busy output covers the whole scan.

Top module: `adc_scan_seq`

## Requirements
- R1: The command frame is the 12-bit word shifted left by 4 and sent MSB first. In the 12-bit word: bit 11 = 1 (write), bits 8:6 = channel, bits 5:4 = power mode, bit 1 = range, bit 0 = coding. Bits 10 and 3 hold the high and low bits of the sequence mode, which is always 0. Bits 9 and 2 are 0. All values come from the settings captured at the trigger.
- R2: SCLK is high whenever chip select (active low) is high. Each frame has exactly 16 rising SCLK edges. MOSI changes only on a falling SCLK edge, and MISO is sampled on the rising edge.
- R3: Chip select stays high for at least 4*SCLK_HALF system clocks (two SCLK periods) between frames.
- R4: Every channel uses two chip-select frames: a command frame, then a read frame whose MOSI bits are all 0. The sample comes from the read frame.
- R5: Read-frame bits 15:12 are the channel tag. The sample is bits 11 down to 12-RES_BITS, and it is presented one clock after chip select rises at the end of the read frame.
- R6: A tag that differs from the commanded channel pulses tag_err for one cycle with smp_valid low, and the scan continues with the next channel.
- R7: Results appear in ascending channel order, and only for channels enabled in the mask captured at the trigger.
- R8: scan_busy rises the cycle after an accepted trigger. It falls the cycle after the last result pulse.
- R9: A trigger while scan_busy is high is ignored: it adds no frames and no results, and its mask has no effect.
- R10: A trigger with an all-zero mask sends no frame and leaves scan_busy low.
- R11: During and straight after reset: cs_n=1, sclk=1, mosi=0, scan_busy=0, smp_valid=0, tag_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Scan trigger, taken when scan_busy is low |
| chan_mask | input | NUM_CH | Channel enable mask, bit i = channel i |
| pwr_mode | input | 2 | Power mode: 1 auto shutdown, 2 full shutdown, 3 normal |
| range_sel | input | 1 | Range select bit |
| coding_sel | input | 1 | Coding select bit (1 = straight binary) |
| scan_busy | output | 1 | High for the duration of a scan |
| smp_valid | output | 1 | One-cycle strobe for an accepted sample |
| smp_chan | output | CH_W | Channel of the current result or error |
| smp_data | output | RES_BITS | Extracted sample |
| tag_err | output | 1 | One-cycle strobe for a tag mismatch |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The timing the bench relies on:
- scan_busy rises one clock after the trigger edge.
- A result strobe appears one clock after chip select rises at the end of a read frame.
- scan_busy falls one clock after the last strobe.

A behavioural model in the bench updates on each rising clock edge from the inputs it drove half a cycle earlier. The bench compares scan_busy with this model on every falling edge. It decodes each frame in a converter model when chip select rises. Result strobes are popped from an expected queue at the falling edge where they are visible, so each output is sampled half a cycle after the register that drives it.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int FRAME_W   = 16;
    localparam int TAG_W     = 4;
    localparam int CMD_SHIFT = 4;

    localparam logic [1:0] SEQ_OFF = 2'b00;

    typedef struct packed {
        logic [1:0] pwr;
        logic       rng;
        logic       cod;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_GO,
        ST_CMD_RUN,
        ST_RD_GO,
        ST_RD_RUN
    } ctl_e;

    function automatic logic [FRAME_W-1:0] make_cmd(logic [2:0] ch, cfg_t c, logic [1:0] seq);
        logic [11:0] w;
        w       = '0;
        w[11]   = 1'b1;
        w[10]   = seq[1];
        w[8:6]  = ch;
        w[5:4]  = c.pwr;
        w[3]    = seq[0];
        w[1]    = c.rng;
        w[0]    = c.cod;
        return {w, {CMD_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/adcseq_pick.sv
module adcseq_pick #(
    parameter int N  = 8,
    parameter int CW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
    import adcseq_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               ready,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi
);
    localparam int HC_W     = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int GAP_CLKS = 4 * HALF;
    localparam int GC_W     = $clog2(GAP_CLKS + 1);
    localparam int LAST_PH  = 2 * FRAME_W;

    logic               active;
    logic [HC_W-1:0]    hc;
    logic [5:0]         ph;
    logic [FRAME_W-1:0] sh;
    logic [GC_W-1:0]    gap_cnt;

    assign ready = !active && (gap_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            mosi    <= 1'b0;
            hc      <= '0;
            ph      <= '0;
            sh      <= '0;
            rx_word <= '0;
            gap_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (gap_cnt != '0) begin
                    gap_cnt <= gap_cnt - 1'b1;
                end else if (go) begin
                    active <= 1'b1;
                    cs_n   <= 1'b0;
                    sh     <= tx_word;
                    hc     <= '0;
                    ph     <= '0;
                end
            end else if (hc != HC_W'(HALF - 1)) begin
                hc <= hc + 1'b1;
            end else begin
                hc <= '0;
                ph <= ph + 1'b1;
                if (ph == 6'(LAST_PH)) begin
                    active  <= 1'b0;
                    cs_n    <= 1'b1;
                    done    <= 1'b1;
                    gap_cnt <= GC_W'(GAP_CLKS - 1);
                end else if (!ph[0]) begin
                    sclk <= 1'b0;
                    mosi <= sh[FRAME_W-1];
                    sh   <= {sh[FRAME_W-2:0], 1'b0};
                end else begin
                    sclk    <= 1'b1;
                    rx_word <= {rx_word[FRAME_W-2:0], miso};
                end
            end
        end
    end

    // Chip-select high time seen from the pins
    logic [GC_W-1:0] cs_hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_hi_cnt <= GC_W'(GAP_CLKS);
        end else if (!cs_n) begin
            cs_hi_cnt <= '0;
        end else if (cs_hi_cnt != GC_W'(GAP_CLKS)) begin
            cs_hi_cnt <= cs_hi_cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk); // R2
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (cs_hi_cnt >= GC_W'(GAP_CLKS))); // R3
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi) |-> $fell(sclk)); // R2
endmodule

// File: rtl/adcseq_decode.sv
module adcseq_decode
    import adcseq_pkg::*;
#(
    parameter int CW  = 3,
    parameter int RES = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic [CW-1:0]      exp_ch,
    output logic               valid,
    output logic               err,
    output logic [CW-1:0]      chan,
    output logic [RES-1:0]     data
);
    logic [TAG_W-1:0] tag;
    logic             match;

    assign tag   = rx_word[FRAME_W-1 -: TAG_W];
    assign match = (tag == {{(TAG_W-CW){1'b0}}, exp_ch});

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            err   <= 1'b0;
            chan  <= '0;
            data  <= '0;
        end else begin
            valid <= done && match;
            err   <= done && !match;
            if (done) begin
                chan <= exp_ch;
                if (match) data <= rx_word[11 -: RES];
            end
        end
    end

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> (valid != err)); // R6
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcseq_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int RES_BITS  = 12,
    parameter int SCLK_HALF = 2,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_start,
    input  logic [NUM_CH-1:0]   chan_mask,
    input  logic [1:0]          pwr_mode,
    input  logic                range_sel,
    input  logic                coding_sel,
    output logic                scan_busy,
    output logic                smp_valid,
    output logic [CH_W-1:0]     smp_chan,
    output logic [RES_BITS-1:0] smp_data,
    output logic                tag_err,
    output logic                spi_cs_n,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    ctl_e               st;
    logic [NUM_CH-1:0]  pend;
    logic [NUM_CH-1:0]  mask_lat;
    logic [CH_W-1:0]    cur;
    cfg_t               cfg_q;

    logic [NUM_CH-1:0]  cur_oh;
    logic [NUM_CH-1:0]  pick_in;
    logic               pick_any;
    logic [CH_W-1:0]    pick_idx;

    logic               frm_go, frm_ready, frm_done;
    logic [FRAME_W-1:0] frm_tx, frm_rx;
    logic               accept;

    always_comb begin
        cur_oh      = '0;
        cur_oh[cur] = 1'b1;
    end

    assign pick_in = (st == ST_IDLE) ? chan_mask : (pend & ~cur_oh);

    adcseq_pick #(.N(NUM_CH), .CW(CH_W)) u_pick (
        .req (pick_in),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign scan_busy = (st != ST_IDLE) || smp_valid || tag_err;
    assign accept    = scan_start && !scan_busy && pick_any;
    assign frm_go    = ((st == ST_CMD_GO) || (st == ST_RD_GO)) && frm_ready;
    assign frm_tx    = (st == ST_CMD_GO) ? make_cmd(3'(cur), cfg_q, SEQ_OFF) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pend     <= '0;
            mask_lat <= '0;
            cur      <= '0;
            cfg_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    pend     <= chan_mask;
                    mask_lat <= chan_mask;
                    cur      <= pick_idx;
                    cfg_q    <= '{pwr: pwr_mode, rng: range_sel, cod: coding_sel};
                    st       <= ST_CMD_GO;
                end
                ST_CMD_GO:  if (frm_ready) st <= ST_CMD_RUN;
                ST_CMD_RUN: if (frm_done)  st <= ST_RD_GO;
                ST_RD_GO:   if (frm_ready) st <= ST_RD_RUN;
                ST_RD_RUN: if (frm_done) begin
                    pend <= pick_in;
                    if (pick_any) begin
                        cur <= pick_idx;
                        st  <= ST_CMD_GO;
                    end else begin
                        st  <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    adcseq_frame #(.HALF(SCLK_HALF)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .go      (frm_go),
        .tx_word (frm_tx),
        .miso    (spi_miso),
        .ready   (frm_ready),
        .done    (frm_done),
        .rx_word (frm_rx),
        .cs_n    (spi_cs_n),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    adcseq_decode #(.CW(CH_W), .RES(RES_BITS)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .done    (frm_done && (st == ST_RD_RUN)),
        .rx_word (frm_rx),
        .exp_ch  (cur),
        .valid   (smp_valid),
        .err     (tag_err),
        .chan    (smp_chan),
        .data    (smp_data)
    );

    // Order tracking for the checks below
    logic            seen;
    logic [CH_W-1:0] last_ch;
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            seen    <= 1'b0;
            last_ch <= '0;
        end else if (smp_valid || tag_err) begin
            seen    <= 1'b1;
            last_ch <= smp_chan;
        end
    end

    AST_BUSY_ON_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (scan_start && !scan_busy && (|chan_mask)) |=> scan_busy); // R8
    AST_EMPTY_NOOP: assert property (@(posedge clk) disable iff (rst)
        (scan_start && !scan_busy && (chan_mask == '0)) |=> !scan_busy); // R10
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (scan_start && scan_busy) |=> $stable(mask_lat)); // R9
    AST_RESULT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (smp_valid || tag_err) |-> mask_lat[smp_chan]); // R7
    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        ((smp_valid || tag_err) && seen) |-> (smp_chan > last_ch)); // R7
endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
    localparam int NCH  = 8;
    localparam int RES  = 12;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_start = 1'b0;
    logic [NCH-1:0] chan_mask = '0;
    logic [1:0] pwr_mode = 2'd3;
    logic range_sel = 1'b1;
    logic coding_sel = 1'b1;
    logic scan_busy, smp_valid, tag_err;
    logic [2:0] smp_chan;
    logic [RES-1:0] smp_data;
    logic spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;

    always #4 clk = ~clk;

    adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(RES), .SCLK_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .scan_start(scan_start), .chan_mask(chan_mask),
        .pwr_mode(pwr_mode), .range_sel(range_sel), .coding_sel(coding_sel),
        .scan_busy(scan_busy), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .tag_err(tag_err), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sample_of(int ch, int scan);
        return (ch * 397 + scan * 1201 + 77) % 4096;
    endfunction

    function automatic int cmd_of(int ch, int pm, int rng, int cod);
        return ((1 << 11) | (ch << 6) | (pm << 4) | (rng << 1) | cod) << 4;
    endfunction

    // Behavioural model
    int  scan_id = 0;
    int  bad_ch = -1;
    bit  m_busy = 0;
    int  m_rem = 0;
    int  q_cmd[$];
    int  q_ch[$];
    int  q_err[$];
    int  q_dat[$];

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0;
            m_rem  <= 0;
        end else begin
            if (scan_start && !m_busy && chan_mask != 0) begin
                scan_id = scan_id + 1;
                for (int i = 0; i < NCH; i++) begin
                    if (chan_mask[i]) begin
                        q_cmd.push_back(cmd_of(i, pwr_mode, range_sel, coding_sel));
                        q_ch.push_back(i);
                        q_err.push_back(i == bad_ch);
                        q_dat.push_back(sample_of(i, scan_id));
                    end
                end
                m_busy <= 1;
                m_rem  <= $countones(chan_mask);
            end else if ((smp_valid || tag_err) && m_rem > 0) begin
                m_rem <= m_rem - 1;
                if (m_rem == 1) m_busy <= 0;
            end
        end
    end

    // Converter model
    int  nrise = 0;
    int  bitn = 0;
    int  frames = 0;
    bit  rd_phase = 0;
    logic [15:0] rxw = '0;
    logic [15:0] resp = '0;

    always @(negedge spi_cs_n) begin
        nrise = 0;
        bitn  = 0;
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            spi_miso = resp[15 - bitn];
            bitn = bitn + 1;
        end
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            rxw = {rxw[14:0], spi_mosi};
            nrise = nrise + 1;
        end
    end
    always @(posedge spi_cs_n) begin
        if (nrise != 0) begin
            frames = frames + 1;
            chk(nrise == 16, "R2 sclk edges per frame", nrise, 16);
            if (!rd_phase) begin
                int ch;
                int e;
                e = (q_cmd.size() > 0) ? q_cmd.pop_front() : -1;
                chk(int'(rxw) == e, "R1 command word", rxw, e);
                ch = (rxw >> 10) & 7;
                resp = {((ch == bad_ch) ? (4'h8 | 4'(ch)) : 4'(ch)), 12'(sample_of(ch, scan_id))};
                rd_phase = 1;
            end else begin
                chk(rxw == 16'h0, "R4 read frame mosi zero", rxw, 0);
                resp = '0;
                rd_phase = 0;
            end
        end
    end

    // Pin monitor, sampled away from the active edge
    logic prev_mosi = 1'b0, prev_sclk = 1'b1;
    int   cs_hi = 1000;
    int   cyc = 0;
    int   results = 0;

    always @(negedge spi_cs_n) begin
        chk(cs_hi >= 4 * HALF, "R3 cs high gap", cs_hi, 4 * HALF);
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (!rst) begin
            chk(scan_busy == m_busy, "R8 busy", scan_busy, m_busy);
            if (spi_cs_n) chk(spi_sclk == 1'b1, "R2 sclk idle high", spi_sclk, 1);
            if (spi_mosi !== prev_mosi)
                chk(prev_sclk == 1'b1 && spi_sclk == 1'b0, "R2 mosi changes on fall", spi_sclk, 0);
            if (smp_valid || tag_err) begin
                results++;
                if (q_ch.size() == 0) begin
                    chk(0, "R9 unexpected result", smp_chan, 0);
                end else begin
                    int ech, eer, eda;
                    ech = q_ch.pop_front();
                    eer = q_err.pop_front();
                    eda = q_dat.pop_front();
                    chk(int'(smp_chan) == ech, "R7 result channel order", smp_chan, ech);
                    chk(tag_err == eer[0], "R6 tag error flag", tag_err, eer);
                    chk(smp_valid == !eer[0], "R6 valid vs error", smp_valid, !eer[0]);
                    if (smp_valid) chk(int'(smp_data) == eda, "R5 sample data", smp_data, eda);
                end
            end
        end
        if (spi_cs_n) cs_hi++; else cs_hi = 0;
        prev_mosi = spi_mosi;
        prev_sclk = spi_sclk;
    end

    task automatic run_scan(input logic [NCH-1:0] m, input int pm, input int rng,
                            input int cod, input int bad);
        int f0, r0;
        f0 = frames;
        r0 = results;
        @(negedge clk);
        bad_ch = bad;
        chan_mask = m;
        pwr_mode = 2'(pm);
        range_sel = rng[0];
        coding_sel = cod[0];
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        while (m_busy || scan_busy) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(frames - f0 == 2 * $countones(m), "R4 two frames per channel", frames - f0, 2 * $countones(m));
        chk(results - r0 == $countones(m), "R7 one result per enabled channel", results - r0, $countones(m));
        chk(q_cmd.size() == 0, "R1 all commands seen", q_cmd.size(), 0);
        bad_ch = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1 && spi_sclk == 1 && spi_mosi == 0, "R11 reset spi pins",
            {spi_cs_n, spi_sclk, spi_mosi}, 3'b110);
        chk(scan_busy == 0 && smp_valid == 0 && tag_err == 0, "R11 reset status",
            {scan_busy, smp_valid, tag_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1 && scan_busy == 0, "R11 after reset", {spi_cs_n, scan_busy}, 2'b10);

        run_scan(8'h01, 3, 1, 1, -1);   // R1 default settings
        run_scan(8'hA5, 1, 0, 0, -1);   // R1 R7 sparse mask, other settings
        run_scan(8'hFF, 2, 1, 0, -1);   // R7 full mask
        run_scan(8'h80, 3, 0, 1, -1);   // R7 top channel only
        run_scan(8'h0C, 3, 1, 1, 2);    // R6 mismatch on channel 2, channel 3 still good

        // R9: trigger while busy is ignored
        begin
            int f0, r0;
            f0 = frames;
            r0 = results;
            @(negedge clk);
            chan_mask = 8'h03;
            scan_start = 1'b1;
            @(negedge clk);
            scan_start = 1'b0;
            repeat (30) @(negedge clk);
            chan_mask = 8'hFF;
            scan_start = 1'b1;
            @(negedge clk);
            scan_start = 1'b0;
            while (m_busy || scan_busy) @(negedge clk);
            repeat (20) @(negedge clk);
            chk(frames - f0 == 4, "R9 frames from first trigger only", frames - f0, 4);
            chk(results - r0 == 2, "R9 results from first trigger only", results - r0, 2);
        end

        // R10: empty mask does nothing
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            chan_mask = '0;
            scan_start = 1'b1;
            @(negedge clk);
            scan_start = 1'b0;
            chk(scan_busy == 0, "R10 busy stays low", scan_busy, 0);
            repeat (40) @(negedge clk);
            chk(frames == f0, "R10 no frames", frames - f0, 0);
            chk(spi_cs_n == 1, "R10 cs idle", spi_cs_n, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule